// File: doc/BRIEF.md
# Egress Descriptor Ring Post Tracker

This block keeps the bookkeeping for a set of egress descriptor rings, each a power of two in size. Software posts work with one memory-mapped store. The store names the ring, the tail index as it stood before the post, the number of new descriptors and the generation bit of that tail. The tracker computes the new tail and the generation that goes with it, stores both, and raises a one-cycle fetch request that carries the ring, the tail and the generation to a descriptor fetch engine. A store with a count of zero is a wake-up: it repeats a fetch request using the stored tail. A store whose count is larger than the ring is refused and flagged.

The fetch engine reports how many descriptors it has taken from a ring. The tracker moves that ring's head pointer and flips the ring's current generation each time the head wraps past the end. A descriptor is valid while its generation bit is the inverse of the ring's current generation. A completion port adds to a rolling 16-bit count of fully processed descriptors. A per-ring flush bit clears that count when it goes from set to clear. A memory-mapped load returns the head, the processed count and the current generation. A configuration port sets a ring's size and returns the ring to its empty state.

Top module: `edma_ring_tracker`

## Requirements
- R1: After synchronous reset, every ring has tail, head, processed count and both generations at 0, its flush bit clear, and size 2^MAX_LOG2 (4096 by default). fetch_req, post_err and rd_valid are low.
- R2: A load or store takes effect only when mmio_addr[28:26] equals 5. The ring is selected by mmio_addr[7:3]. Any other region code leaves all state and outputs unchanged, and a load to it gives no rd_valid.
- R3: An accepted store with count mmio_wdata[31:16] nonzero sets the ring's tail to (mmio_wdata[15:0] masked to the ring size + count) mod size. In the next cycle it raises fetch_req for one cycle, with fetch_ring set to the ring and fetch_tail set to the new tail.
- R4: For that store, fetch_gen and the stored tail generation equal mmio_wdata[32] XOR wrap, where wrap is 1 when masked index + count is at least the ring size. A count equal to the ring size is accepted.
- R5: A store with count 0 leaves the tail unchanged. It still raises fetch_req in the next cycle, carrying the stored tail and stored tail generation, whatever index the store carries.
- R6: A store whose count exceeds the ring size pulses post_err one cycle later. It raises no fetch_req and leaves the tail unchanged. fetch_req and post_err are never high together.
- R7: An accepted load gives rd_valid one cycle later. rd_data[15:0] is the head, rd_data[31:16] is the processed count, rd_data[32] is the current generation, and the upper bits are 0. The values are those from before any update presented in the same cycle.
- R8: adv_valid with adv_num ≤ size sets head to (head + adv_num) mod size. The current generation flips when head + adv_num is at least the size.
- R9: cmp_valid adds cmp_num to the ring's processed count, modulo 2^16.
- R10: flush_wr writes flush_val into the ring's flush bit. A 1-to-0 change clears the processed count, and a completion in that same cycle is discarded. Setting the bit does not change the count.
- R11: cfg_wr sets the ring's size to 2^cfg_log2, with cfg_log2 saturated at MAX_LOG2. It zeroes that ring's tail, head, generations, count and flush bit. Any post, advance, completion or flush presented in the same cycle is discarded, and no fetch_req or post_err results from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mmio_wr | input | 1 | Post store strobe |
| mmio_rd | input | 1 | Status load strobe |
| mmio_addr | input | ADDR_W (40) | Access address: region in [28:26], ring in [7:3] |
| mmio_wdata | input | 64 | Store data: index [15:0], count [31:16], generation [32] |
| rd_valid | output | 1 | Load data valid |
| rd_data | output | 64 | Head [15:0], processed count [31:16], generation [32] |
| post_err | output | 1 | Oversized post refused |
| fetch_req | output | 1 | Fetch request pulse |
| fetch_ring | output | RING_W (5) | Ring to fetch from |
| fetch_tail | output | IDX_W (16) | Tail bound for the fetch |
| fetch_gen | output | 1 | Generation of that tail |
| adv_valid | input | 1 | Fetch engine head advance |
| adv_ring | input | RING_W | Ring advanced |
| adv_num | input | IDX_W | Descriptors taken |
| cmp_valid | input | 1 | Completion report |
| cmp_ring | input | RING_W | Ring completed |
| cmp_num | input | CNT_W (16) | Descriptors completed |
| flush_wr | input | 1 | Flush bit write |
| flush_ring | input | RING_W | Ring of the flush write |
| flush_val | input | 1 | New flush bit value |
| cfg_wr | input | 1 | Ring configuration write |
| cfg_ring | input | RING_W | Ring configured |
| cfg_log2 | input | LOG2_W (4) | Log2 of the ring size |

## Verification
A corrupted tail or tail generation appears on fetch_tail and fetch_gen at the next post or zero-count wake-up, one cycle after that store. A wrong head, count or current generation appears in rd_data one cycle after the next load of that ring. The bench therefore reads rings back after each advance, completion, flush and configuration step. It also repeats zero-count posts after operations that must not touch the tail, which exposes a lost or misdirected write in one cycle. A wrong size shows up as a wrong wrap or a wrong accept/refuse decision at the boundary counts size and size+1.

// File: rtl/edma_trk_pkg.sv
package edma_trk_pkg;
  localparam int REGION_LSB  = 26;
  localparam int REGION_W    = 3;
  localparam logic [REGION_W-1:0] REGION_POST = 3'd5;
  localparam int RING_LSB    = 3;
  localparam int WD_IDX_LSB  = 0;
  localparam int WD_CNT_LSB  = 16;
  localparam int WD_GEN_BIT  = 32;
  localparam int DATA_W      = 64;
endpackage

// File: rtl/edma_ring_store.sv
module edma_ring_store #(
  parameter int W   = 16,
  parameter int AW  = 5,
  parameter int NRD = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= RST_VAL;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/edma_ring_add.sv
module edma_ring_add #(
  parameter int W      = 16,
  parameter int LOG2_W = 4
) (
  input  logic [W-1:0]      base,
  input  logic [W-1:0]      add,
  input  logic [LOG2_W-1:0] log2,
  output logic [W-1:0]      res,
  output logic              wrap,
  output logic              over
);
  localparam int SW = W + 1;

  logic [SW-1:0] size, mask, base_m, sum;

  always_comb begin
    size   = SW'(1) << log2;
    mask   = size - SW'(1);
    base_m = {1'b0, base} & mask;
    sum    = base_m + {1'b0, add};
    wrap   = (sum >= size);
    over   = ({1'b0, add} > size);
    res    = W'(sum & mask);
  end
endmodule

// File: rtl/edma_addr_dec.sv
module edma_addr_dec
  import edma_trk_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int RING_W = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [RING_W-1:0] ring
);
  logic unused_addr;
  assign unused_addr = ^addr;
  assign hit  = (addr[REGION_LSB +: REGION_W] == REGION_POST);
  assign ring = addr[RING_LSB +: RING_W];
endmodule

// File: rtl/edma_ring_tracker.sv
module edma_ring_tracker
  import edma_trk_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int RING_W   = 5,
  parameter int IDX_W    = 16,
  parameter int CNT_W    = 16,
  parameter int MAX_LOG2 = 12,
  parameter int LOG2_W   = $clog2(MAX_LOG2 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mmio_wr,
  input  logic              mmio_rd,
  input  logic [ADDR_W-1:0] mmio_addr,
  input  logic [63:0]       mmio_wdata,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic              post_err,
  output logic              fetch_req,
  output logic [RING_W-1:0] fetch_ring,
  output logic [IDX_W-1:0]  fetch_tail,
  output logic              fetch_gen,
  input  logic              adv_valid,
  input  logic [RING_W-1:0] adv_ring,
  input  logic [IDX_W-1:0]  adv_num,
  input  logic              cmp_valid,
  input  logic [RING_W-1:0] cmp_ring,
  input  logic [CNT_W-1:0]  cmp_num,
  input  logic              flush_wr,
  input  logic [RING_W-1:0] flush_ring,
  input  logic              flush_val,
  input  logic              cfg_wr,
  input  logic [RING_W-1:0] cfg_ring,
  input  logic [LOG2_W-1:0] cfg_log2
);
  localparam int NRING = 1 << RING_W;
  localparam int PW    = IDX_W + 1;
  localparam logic [LOG2_W-1:0] LOG2_MAX = LOG2_W'(MAX_LOG2);

  // decode
  logic              hit;
  logic [RING_W-1:0] ring_sel;
  edma_addr_dec #(.ADDR_W(ADDR_W), .RING_W(RING_W)) u_dec (
    .addr(mmio_addr), .hit(hit), .ring(ring_sel)
  );

  logic unused_wdata;
  assign unused_wdata = ^mmio_wdata[DATA_W-1:WD_GEN_BIT+1];

  logic [IDX_W-1:0] p_idx;
  logic [IDX_W-1:0] p_cnt;
  logic             p_gen;
  assign p_idx = mmio_wdata[WD_IDX_LSB +: IDX_W];
  assign p_cnt = IDX_W'(mmio_wdata[WD_CNT_LSB +: CNT_W]);
  assign p_gen = mmio_wdata[WD_GEN_BIT];

  logic wr_go, rd_go;
  assign wr_go = mmio_wr & hit;
  assign rd_go = mmio_rd & hit;

  // ring size store: port 0 post ring, port 1 advance ring
  logic [LOG2_W-1:0]             cfg_sat;
  logic [1:0][RING_W-1:0]        sz_ra;
  logic [1:0][LOG2_W-1:0]        sz_rd;
  assign cfg_sat  = (cfg_log2 > LOG2_MAX) ? LOG2_MAX : cfg_log2;
  assign sz_ra[0] = ring_sel;
  assign sz_ra[1] = adv_ring;

  edma_ring_store #(.W(LOG2_W), .AW(RING_W), .NRD(2), .RST_VAL(LOG2_MAX)) u_size (
    .clk(clk), .rst(rst), .we(cfg_wr), .waddr(cfg_ring), .wdata(cfg_sat),
    .raddr(sz_ra), .rdata(sz_rd)
  );

  // post path
  logic [IDX_W-1:0] p_tail;
  logic             p_wrap, p_over;
  edma_ring_add #(.W(IDX_W), .LOG2_W(LOG2_W)) u_post_add (
    .base(p_idx), .add(p_cnt), .log2(sz_rd[0]),
    .res(p_tail), .wrap(p_wrap), .over(p_over)
  );

  logic [0:0][RING_W-1:0] tl_ra;
  logic [0:0][PW-1:0]     tl_rd;
  logic                   tl_we;
  logic [RING_W-1:0]      tl_wa;
  logic [PW-1:0]          tl_wd;
  assign tl_ra[0] = ring_sel;

  logic             p_zero, post_ok, err_ev;
  logic [IDX_W-1:0] f_tail;
  logic             f_gen;

  always_comb begin
    p_zero  = (p_cnt == '0);
    post_ok = wr_go & ~cfg_wr & ~p_over;
    err_ev  = wr_go & ~cfg_wr & p_over;
    if (p_zero) begin
      f_tail = tl_rd[0][IDX_W-1:0];
      f_gen  = tl_rd[0][IDX_W];
    end else begin
      f_tail = p_tail;
      f_gen  = p_gen ^ p_wrap;
    end
    tl_we = cfg_wr | (post_ok & ~p_zero);
    tl_wa = cfg_wr ? cfg_ring : ring_sel;
    tl_wd = cfg_wr ? '0 : {f_gen, f_tail};
  end

  edma_ring_store #(.W(PW), .AW(RING_W), .NRD(1)) u_tail (
    .clk(clk), .rst(rst), .we(tl_we), .waddr(tl_wa), .wdata(tl_wd),
    .raddr(tl_ra), .rdata(tl_rd)
  );

  // head path: port 0 advance ring, port 1 read ring
  logic [1:0][RING_W-1:0] hd_ra;
  logic [1:0][PW-1:0]     hd_rd;
  logic                   hd_we;
  logic [RING_W-1:0]      hd_wa;
  logic [PW-1:0]          hd_wd;
  logic [IDX_W-1:0]       h_new;
  logic                   h_wrap, h_over;
  assign hd_ra[0] = adv_ring;
  assign hd_ra[1] = ring_sel;

  edma_ring_add #(.W(IDX_W), .LOG2_W(LOG2_W)) u_head_add (
    .base(hd_rd[0][IDX_W-1:0]), .add(adv_num), .log2(sz_rd[1]),
    .res(h_new), .wrap(h_wrap), .over(h_over)
  );

  logic unused_h_over;
  assign unused_h_over = h_over;

  always_comb begin
    hd_we = cfg_wr | adv_valid;
    hd_wa = cfg_wr ? cfg_ring : adv_ring;
    hd_wd = cfg_wr ? '0 : {hd_rd[0][IDX_W] ^ h_wrap, h_new};
  end

  edma_ring_store #(.W(PW), .AW(RING_W), .NRD(2)) u_head (
    .clk(clk), .rst(rst), .we(hd_we), .waddr(hd_wa), .wdata(hd_wd),
    .raddr(hd_ra), .rdata(hd_rd)
  );

  // processed count and flush bits: port 0 completion ring, port 1 read ring
  logic [NRING-1:0]       flush_q;
  logic [1:0][RING_W-1:0] ct_ra;
  logic [1:0][CNT_W-1:0]  ct_rd;
  logic                   ct_we, fl_fall;
  logic [RING_W-1:0]      ct_wa;
  logic [CNT_W-1:0]       ct_wd;
  assign ct_ra[0] = cmp_ring;
  assign ct_ra[1] = ring_sel;

  always_comb begin
    fl_fall = ~cfg_wr & flush_wr & flush_q[flush_ring] & ~flush_val;
    ct_we   = cfg_wr | fl_fall | cmp_valid;
    if (cfg_wr) begin
      ct_wa = cfg_ring;
      ct_wd = '0;
    end else if (fl_fall) begin
      ct_wa = flush_ring;
      ct_wd = '0;
    end else begin
      ct_wa = cmp_ring;
      ct_wd = ct_rd[0] + cmp_num;
    end
  end

  edma_ring_store #(.W(CNT_W), .AW(RING_W), .NRD(2)) u_count (
    .clk(clk), .rst(rst), .we(ct_we), .waddr(ct_wa), .wdata(ct_wd),
    .raddr(ct_ra), .rdata(ct_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_q <= '0;
    end else if (cfg_wr) begin
      flush_q[cfg_ring] <= 1'b0;
    end else if (flush_wr) begin
      flush_q[flush_ring] <= flush_val;
    end
  end

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_req  <= 1'b0;
      fetch_ring <= '0;
      fetch_tail <= '0;
      fetch_gen  <= 1'b0;
      post_err   <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
    end else begin
      fetch_req <= post_ok;
      post_err  <= err_ev;
      rd_valid  <= rd_go;
      if (post_ok) begin
        fetch_ring <= ring_sel;
        fetch_tail <= f_tail;
        fetch_gen  <= f_gen;
      end
      if (rd_go) begin
        rd_data <= '0;
        rd_data[WD_IDX_LSB +: IDX_W] <= hd_rd[1][IDX_W-1:0];
        rd_data[WD_CNT_LSB +: CNT_W] <= ct_rd[1];
        rd_data[WD_GEN_BIT]          <= hd_rd[1][IDX_W];
      end
    end
  end
endmodule

// File: rtl/edma_ring_tracker_chk.sv
module edma_ring_tracker_chk #(
  parameter int IDX_W    = 16,
  parameter int MAX_LOG2 = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             mmio_wr,
  input logic             mmio_rd,
  input logic             cfg_wr,
  input logic             fetch_req,
  input logic             post_err,
  input logic             rd_valid,
  input logic [IDX_W-1:0] fetch_tail
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!fetch_req && !post_err && !rd_valid));

  // R6
  post_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(fetch_req && post_err));

  // R3
  fetch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> ($past(mmio_wr) && !$past(cfg_wr)));

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    post_err |-> ($past(mmio_wr) && !$past(cfg_wr)));

  // R7
  rd_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(mmio_rd));

  // R3
  tail_range_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_req |-> ((32'(fetch_tail) >> MAX_LOG2) == 32'd0));
endmodule

bind edma_ring_tracker edma_ring_tracker_chk #(.IDX_W(IDX_W), .MAX_LOG2(MAX_LOG2)) u_chk (
  .clk(clk), .rst(rst), .mmio_wr(mmio_wr), .mmio_rd(mmio_rd), .cfg_wr(cfg_wr),
  .fetch_req(fetch_req), .post_err(post_err), .rd_valid(rd_valid),
  .fetch_tail(fetch_tail)
);

// File: tb/tb_edma_ring_tracker.sv
module tb_edma_ring_tracker;
  localparam logic [2:0] OP_POST = 3'd0, OP_READ = 3'd1, OP_ADV = 3'd2,
                         OP_CMP = 3'd3, OP_FLUSH = 3'd4, OP_CFG = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [4:0]  ring;
    logic [15:0] a;
    logic [15:0] b;
    logic        g;
    logic        ef;
    logic        ee;
    logic [32:0] ex;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{OP_CFG,   5'd2,  16'd3,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd11}, // R11 size 8
    '{OP_POST,  5'd2,  16'd0,     16'd5,    1'b0, 1'b1, 1'b0, 33'd5,         4'd3},  // R3
    '{OP_READ,  5'd2,  16'd0,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd7},  // R7
    '{OP_POST,  5'd2,  16'd5,     16'd5,    1'b0, 1'b1, 1'b0, 33'h10002,     4'd4},  // R4 wrap
    '{OP_POST,  5'd2,  16'd2,     16'd9,    1'b0, 1'b0, 1'b1, 33'd0,         4'd6},  // R6
    '{OP_POST,  5'd2,  16'd2,     16'd8,    1'b1, 1'b1, 1'b0, 33'd2,         4'd4},  // R4 count==size
    '{OP_POST,  5'd2,  16'd7,     16'd0,    1'b1, 1'b1, 1'b0, 33'd2,         4'd5},  // R5
    '{OP_ADV,   5'd2,  16'd6,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd8},  // R8
    '{OP_ADV,   5'd2,  16'd3,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd8},  // R8
    '{OP_CMP,   5'd2,  16'd4,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd9},  // R9
    '{OP_CMP,   5'd2,  16'd65534, 16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd9},  // R9
    '{OP_READ,  5'd2,  16'd0,     16'd0,    1'b0, 1'b0, 1'b0, {1'b1,16'd2,16'd1}, 4'd8}, // R8 R9
    '{OP_FLUSH, 5'd2,  16'd1,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd10}, // R10
    '{OP_READ,  5'd2,  16'd0,     16'd0,    1'b0, 1'b0, 1'b0, {1'b1,16'd2,16'd1}, 4'd10}, // R10
    '{OP_FLUSH, 5'd2,  16'd0,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd10}, // R10
    '{OP_READ,  5'd2,  16'd0,     16'd0,    1'b0, 1'b0, 1'b0, {1'b1,16'd0,16'd1}, 4'd10}, // R10
    '{OP_CFG,   5'd2,  16'd15,    16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd11}, // R11
    '{OP_READ,  5'd2,  16'd0,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd11}, // R11
    '{OP_POST,  5'd2,  16'd4000,  16'd200,  1'b0, 1'b1, 1'b0, {16'd0,1'b1,16'd104}, 4'd11}, // R11 sat
    '{OP_POST,  5'd31, 16'd0,     16'd4096, 1'b0, 1'b1, 1'b0, 33'h10000,     4'd1},  // R1 size
    '{OP_POST,  5'd31, 16'd0,     16'd4097, 1'b0, 1'b0, 1'b1, 33'd0,         4'd1},  // R1
    '{OP_READ,  5'd5,  16'd0,     16'd0,    1'b0, 1'b0, 1'b0, 33'd0,         4'd1}   // R1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mmio_wr, mmio_rd;
  logic [39:0] mmio_addr;
  logic [63:0] mmio_wdata;
  logic        rd_valid, post_err, fetch_req, fetch_gen;
  logic [63:0] rd_data;
  logic [4:0]  fetch_ring;
  logic [15:0] fetch_tail;
  logic        adv_valid, cmp_valid, flush_wr, flush_val, cfg_wr;
  logic [4:0]  adv_ring, cmp_ring, flush_ring, cfg_ring;
  logic [15:0] adv_num, cmp_num;
  logic [3:0]  cfg_log2;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  edma_ring_tracker dut (
    .clk(clk), .rst(rst), .mmio_wr(mmio_wr), .mmio_rd(mmio_rd),
    .mmio_addr(mmio_addr), .mmio_wdata(mmio_wdata), .rd_valid(rd_valid),
    .rd_data(rd_data), .post_err(post_err), .fetch_req(fetch_req),
    .fetch_ring(fetch_ring), .fetch_tail(fetch_tail), .fetch_gen(fetch_gen),
    .adv_valid(adv_valid), .adv_ring(adv_ring), .adv_num(adv_num),
    .cmp_valid(cmp_valid), .cmp_ring(cmp_ring), .cmp_num(cmp_num),
    .flush_wr(flush_wr), .flush_ring(flush_ring), .flush_val(flush_val),
    .cfg_wr(cfg_wr), .cfg_ring(cfg_ring), .cfg_log2(cfg_log2)
  );

  function automatic logic [39:0] mk_addr(input logic [2:0] region, input logic [4:0] ring);
    logic [39:0] a;
    a = '0;
    a[28:26] = region;
    a[7:3]   = ring;
    return a;
  endfunction

  task automatic idle();
    mmio_wr = 0; mmio_rd = 0; mmio_addr = '0; mmio_wdata = '0;
    adv_valid = 0; adv_ring = '0; adv_num = '0;
    cmp_valid = 0; cmp_ring = '0; cmp_num = '0;
    flush_wr = 0; flush_ring = '0; flush_val = 0;
    cfg_wr = 0; cfg_ring = '0; cfg_log2 = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic set_post(input logic [2:0] rg, input logic [4:0] ring,
                          input logic [15:0] idx, input logic [15:0] cnt, input logic g);
    mmio_wr = 1; mmio_addr = mk_addr(rg, ring);
    mmio_wdata = {31'd0, g, cnt, idx};
  endtask

  task automatic set_read(input logic [2:0] rg, input logic [4:0] ring);
    mmio_rd = 1; mmio_addr = mk_addr(rg, ring);
  endtask

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 outputs quiet", {61'd0, fetch_req, post_err, rd_valid}, 64'd0);
    set_read(3'd5, 5'd0); tick();
    chk("R1 ring0 zero", {63'd0, rd_valid}, 64'd1);
    chk("R1 ring0 data", rd_data, 64'd0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_POST:  set_post(3'd5, VEC[i].ring, VEC[i].a, VEC[i].b, VEC[i].g);
        OP_READ:  set_read(3'd5, VEC[i].ring);
        OP_ADV:   begin adv_valid = 1; adv_ring = VEC[i].ring; adv_num = VEC[i].a; end
        OP_CMP:   begin cmp_valid = 1; cmp_ring = VEC[i].ring; cmp_num = VEC[i].a; end
        OP_FLUSH: begin flush_wr = 1; flush_ring = VEC[i].ring; flush_val = VEC[i].a[0]; end
        default:  begin cfg_wr = 1; cfg_ring = VEC[i].ring; cfg_log2 = VEC[i].a[3:0]; end
      endcase
      tick();
      chk($sformatf("R%0d vec%0d fetch_req", VEC[i].req, i), {63'd0, fetch_req}, {63'd0, VEC[i].ef});
      chk($sformatf("R%0d vec%0d post_err", VEC[i].req, i), {63'd0, post_err}, {63'd0, VEC[i].ee});
      if (VEC[i].ef)
        chk($sformatf("R%0d vec%0d ring/gen/tail", VEC[i].req, i),
            {42'd0, fetch_ring, fetch_gen, fetch_tail}, {42'd0, VEC[i].ring, VEC[i].ex[16:0]});
      if (VEC[i].op == OP_READ)
        chk($sformatf("R%0d vec%0d rd", VEC[i].req, i), {rd_valid, rd_data[62:0]},
            {1'b1, 30'd0, VEC[i].ex});
    end

    // R2 wrong region store and load are ignored
    set_post(3'd4, 5'd2, 16'd0, 16'd1, 1'b0); tick();
    chk("R2 foreign store", {62'd0, fetch_req, post_err}, 64'd0);
    set_read(3'd6, 5'd2); tick();
    chk("R2 foreign load", {63'd0, rd_valid}, 64'd0);
    set_post(3'd5, 5'd2, 16'd9, 16'd0, 1'b0); tick();
    chk("R2 tail kept", {46'd0, fetch_req, fetch_gen, fetch_tail}, {46'd0, 1'b1, 1'b1, 16'd104});

    // R7 load sees state from before a same-cycle completion
    set_read(3'd5, 5'd2); cmp_valid = 1; cmp_ring = 5'd2; cmp_num = 16'd7; tick();
    chk("R7 pre-update read", rd_data, 64'd0);
    set_read(3'd5, 5'd2); tick();
    chk("R7 post-update read", rd_data, 64'h0000_0000_0007_0000);

    // R10 flush clear beats a same-cycle completion
    flush_wr = 1; flush_ring = 5'd2; flush_val = 1; tick();
    flush_wr = 1; flush_ring = 5'd2; flush_val = 0;
    cmp_valid = 1; cmp_ring = 5'd2; cmp_num = 16'd5; tick();
    set_read(3'd5, 5'd2); tick();
    chk("R10 clear wins", rd_data, 64'd0);

    // R11 configuration discards a same-cycle post
    set_post(3'd5, 5'd2, 16'd0, 16'd1, 1'b0);
    cfg_wr = 1; cfg_ring = 5'd2; cfg_log2 = 4'd3; tick();
    chk("R11 post dropped", {62'd0, fetch_req, post_err}, 64'd0);
    set_post(3'd5, 5'd2, 16'd5, 16'd0, 1'b1); tick();
    chk("R11 tail cleared", {46'd0, fetch_req, fetch_gen, fetch_tail}, {46'd0, 1'b1, 1'b0, 16'd0});

    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule